// File: doc/BRIEF.md
# Transmit Source Address Inserter

This block sits in the outgoing byte stream of an Ethernet MAC, ahead of the CRC generator. It can overwrite the source address field of every frame with a six-byte station address held in a small local store. Each frame starts with a six-byte destination address. The source address comes next, in frame bytes 6 to 11. Every other byte passes through unchanged, and each byte leaves the block exactly one clock after it arrives. Valid and the frame markers travel with the data.

Software loads the store one byte at a time through a register port. It writes the slot number to an index register and the byte to a data register. It then pulses a strobe register: first a 1, then a 0. The falling step copies the data into the indexed slot. Slot 0 goes on the wire first, so the address 11:22:33:44:55:66 comes out as 0x11 first and 0x66 last. A separate enable register turns substitution on and off. The enable value is sampled at each start-of-frame, so a frame is always either fully substituted or fully untouched.

Top module: `tx_srcaddr_inserter`

## Requirements
- R1: After reset the outputs are low, the enable is off and all six store slots hold 0x00. Enabling substitution without programming the store therefore writes 0x00 into frame bytes 6 to 11.
- R2: Each input byte appears at the output exactly one cycle later. Valid, start-of-frame and end-of-frame are delayed to match, and no output byte appears without an input byte.
- R3: While the enable register (address 0x07, bit 0) holds 0 at start-of-frame, every byte of that frame passes unchanged.
- R4: While the enable holds 1 at start-of-frame, frame bytes 6 to 11 are replaced by store slots 0 to 5 in that order. Frame byte 0 is the byte marked start-of-frame.
- R5: A slot is written only when address 0x0A receives a write with bit 0 = 0 and the preceding write to 0x0A had bit 0 = 1. A 0 without a preceding 1 commits nothing. A 1 on its own commits nothing.
- R6: The slot written is the value in the index register (address 0x08+1 = 0x09). The byte stored is the value held in the data register (address 0x08) at the moment of commit. An index of 6 or more commits nothing.
- R7: A change to the enable takes effect from the next start-of-frame. A frame in flight keeps the setting it started with.
- R8: Bytes before position 6 and after position 11 are never changed, including those of frames shorter than 12 bytes.
- R9: Idle cycles (valid low) inside a frame do not advance the byte position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | Input byte is first of frame |
| in_eof | input | 1 | Input byte is last of frame |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_sof | output | 1 | Output byte is first of frame |
| out_eof | output | 1 | Output byte is last of frame |
| out_data | output | 8 | Output byte |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid alignment;
- that bytes outside the address window, and every byte of a frame with substitution off, come out unchanged;
- that the store changes only on a completed strobe pulse;
- that the per-frame enable and the byte position change only on start-of-frame or on valid bytes.

Other behaviours only the bench scenarios can show:
- that the substituted bytes come out in slot order;
- that the reset store reads as zeros;
- that an out-of-range index and a lone strobe edge leave the store unchanged;
- that an enable write in the middle of a frame is deferred;
- how gapped and short frames behave.

// File: rtl/sai_pkg.sv
package sai_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              sof;
    logic              eof;
    logic [BYTE_W-1:0] data;
  } sai_beat_t;
endpackage

// File: rtl/sai_rst_sync.sv
module sai_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/sai_regs.sv
module sai_regs #(
  parameter int          SLOTS      = 6,
  parameter int          RA_W       = 8,
  parameter logic [7:0]  ADDR_EN    = 8'h07,
  parameter logic [7:0]  ADDR_DATA  = 8'h08,
  parameter logic [7:0]  ADDR_INDEX = 8'h09,
  parameter logic [7:0]  ADDR_STRB  = 8'h0A
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 reg_wr,
  input  logic [RA_W-1:0]                      reg_addr,
  input  logic [sai_pkg::BYTE_W-1:0]           reg_wdata,
  output logic                                 en_o,
  output logic [SLOTS-1:0][sai_pkg::BYTE_W-1:0] store_o
);
  import sai_pkg::*;
  localparam int SEL_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [BYTE_W-1:0] SLOTS_L = BYTE_W'(SLOTS);

  logic                         en_q, en_d;
  logic [BYTE_W-1:0]            idx_q, idx_d;
  logic [BYTE_W-1:0]            dat_q, dat_d;
  logic                         arm_q, arm_d;
  logic [SLOTS-1:0][BYTE_W-1:0] store_q, store_d;
  logic                         hit_en, hit_dat, hit_idx, hit_stb;
  logic                         commit;

  always_comb begin
    hit_en  = reg_wr && (reg_addr == RA_W'(ADDR_EN));
    hit_dat = reg_wr && (reg_addr == RA_W'(ADDR_DATA));
    hit_idx = reg_wr && (reg_addr == RA_W'(ADDR_INDEX));
    hit_stb = reg_wr && (reg_addr == RA_W'(ADDR_STRB));
    commit  = hit_stb && !reg_wdata[0] && arm_q && (idx_q < SLOTS_L);
  end

  always_comb begin
    en_d    = en_q;
    idx_d   = idx_q;
    dat_d   = dat_q;
    arm_d   = arm_q;
    store_d = store_q;
    if (hit_en)  en_d  = reg_wdata[0];
    if (hit_idx) idx_d = reg_wdata;
    if (hit_dat) dat_d = reg_wdata;
    if (hit_stb) arm_d = reg_wdata[0];
    if (commit)  store_d[idx_q[SEL_W-1:0]] = dat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      idx_q   <= '0;
      dat_q   <= '0;
      arm_q   <= 1'b0;
      store_q <= '0;
    end else begin
      en_q  <= en_d;
      idx_q <= idx_d;
      dat_q <= dat_d;
      arm_q <= arm_d;
      if (commit) store_q <= store_d;
    end
  end

  assign en_o    = en_q;
  assign store_o = store_q;

  assert_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_stb && !reg_wdata[0] && arm_q && idx_q < SLOTS_L)
      |=> store_q[$past(idx_q[SEL_W-1:0])] == $past(dat_q));

  assert_no_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_stb || reg_wdata[0] || !arm_q) |=> $stable(store_q));

  assert_bad_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q >= SLOTS_L) |=> $stable(store_q));
endmodule

// File: rtl/sai_pos.sv
module sai_pos #(
  parameter int OFFSET = 6,
  parameter int SLOTS  = 6
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        in_valid,
  input  logic                                        in_sof,
  input  logic                                        reg_en,
  output logic [$clog2(OFFSET+SLOTS+1)-1:0]           pos_o,
  output logic                                        frame_en_o
);
  localparam int POS_W = $clog2(OFFSET + SLOTS + 1);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [POS_W-1:0] cnt_q, cnt_d;
  logic             fen_q, fen_d;
  logic             start;

  always_comb begin
    start = in_valid && in_sof;
    cnt_d = cnt_q;
    fen_d = fen_q;
    if (in_valid) begin
      if (in_sof)                cnt_d = POS_W'(1);
      else if (cnt_q != POS_MAX) cnt_d = cnt_q + POS_W'(1);
    end
    if (start) fen_d = reg_en;
    pos_o      = in_sof ? '0 : cnt_q;
    frame_en_o = start ? reg_en : fen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      fen_q <= 1'b0;
    end else begin
      if (in_valid) cnt_q <= cnt_d;
      if (start)    fen_q <= fen_d;
    end
  end

  assert_hold_pos_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cnt_q));

  assert_frame_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_sof) |=> $stable(fen_q));
endmodule

// File: rtl/sai_subst.sv
module sai_subst #(
  parameter int OFFSET = 6,
  parameter int SLOTS  = 6
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  in_valid,
  input  sai_pkg::sai_beat_t                    in_beat,
  input  logic [$clog2(OFFSET+SLOTS+1)-1:0]     pos,
  input  logic                                  frame_en,
  input  logic [SLOTS-1:0][sai_pkg::BYTE_W-1:0] store,
  output logic                                  out_valid,
  output sai_pkg::sai_beat_t                    out_beat
);
  import sai_pkg::*;
  localparam int POS_W = $clog2(OFFSET + SLOTS + 1);
  localparam int SEL_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [POS_W-1:0] LO = POS_W'(OFFSET);
  localparam logic [POS_W-1:0] HI = POS_W'(OFFSET + SLOTS);

  logic             in_window, sel;
  logic [POS_W-1:0] rel;
  sai_beat_t        beat_d, beat_q;
  logic             vld_q;

  always_comb begin
    in_window = (pos >= LO) && (pos < HI);
    sel       = frame_en && in_window;
    rel       = pos - LO;
    beat_d    = in_beat;
    if (sel) beat_d.data = store[rel[SEL_W-1:0]];
    if (!in_valid) begin
      beat_d.sof  = 1'b0;
      beat_d.eof  = 1'b0;
      beat_d.data = beat_q.data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      beat_q <= '0;
    end else begin
      vld_q  <= in_valid;
      beat_q <= beat_d;
    end
  end

  assign out_valid = vld_q;
  assign out_beat  = beat_q;

  assert_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_valid && out_beat.sof == $past(in_beat.sof)
                  && out_beat.eof == $past(in_beat.eof)));

  assert_no_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_pass_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !frame_en) |=> out_beat.data == $past(in_beat.data));

  assert_pass_outside_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_window) |=> out_beat.data == $past(in_beat.data));
endmodule

// File: rtl/tx_srcaddr_inserter.sv
module tx_srcaddr_inserter #(
  parameter int         OFFSET     = 6,
  parameter int         SLOTS      = 6,
  parameter int         RA_W       = 8,
  parameter logic [7:0] ADDR_EN    = 8'h07,
  parameter logic [7:0] ADDR_DATA  = 8'h08,
  parameter logic [7:0] ADDR_INDEX = 8'h09,
  parameter logic [7:0] ADDR_STRB  = 8'h0A
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [7:0]      reg_wdata,
  input  logic            in_valid,
  input  logic            in_sof,
  input  logic            in_eof,
  input  logic [7:0]      in_data,
  output logic            out_valid,
  output logic            out_sof,
  output logic            out_eof,
  output logic [7:0]      out_data
);
  import sai_pkg::*;
  localparam int POS_W = $clog2(OFFSET + SLOTS + 1);

  logic                         rst_n_s;
  logic                         en;
  logic [SLOTS-1:0][BYTE_W-1:0] store;
  logic [POS_W-1:0]             pos;
  logic                         frame_en;
  sai_beat_t                    beat_in, beat_out;

  assign beat_in = '{sof: in_sof, eof: in_eof, data: in_data};

  sai_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  sai_regs #(
    .SLOTS(SLOTS), .RA_W(RA_W), .ADDR_EN(ADDR_EN), .ADDR_DATA(ADDR_DATA),
    .ADDR_INDEX(ADDR_INDEX), .ADDR_STRB(ADDR_STRB)
  ) u_regs (
    .clk(clk), .rst_n(rst_n_s), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .en_o(en), .store_o(store)
  );

  sai_pos #(.OFFSET(OFFSET), .SLOTS(SLOTS)) u_pos (
    .clk(clk), .rst_n(rst_n_s), .in_valid(in_valid), .in_sof(in_sof),
    .reg_en(en), .pos_o(pos), .frame_en_o(frame_en)
  );

  sai_subst #(.OFFSET(OFFSET), .SLOTS(SLOTS)) u_subst (
    .clk(clk), .rst_n(rst_n_s), .in_valid(in_valid), .in_beat(beat_in),
    .pos(pos), .frame_en(frame_en), .store(store),
    .out_valid(out_valid), .out_beat(beat_out)
  );

  assign out_sof  = beat_out.sof;
  assign out_eof  = beat_out.eof;
  assign out_data = beat_out.data;
endmodule

// File: tb/tx_srcaddr_inserter_bench.sv
module tx_srcaddr_inserter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = '0;
  logic       out_valid, out_sof, out_eof;
  logic [7:0] out_data;

  typedef struct {
    logic [7:0] d;
    logic       s;
    logic       e;
    int         cyc;
    string      tag;
  } exp_t;

  exp_t       q[$];
  int         errors = 0;
  int         checks = 0;
  int         cyc = 0;
  logic [7:0] m_store [6];
  logic       m_en = 1'b0;
  logic       m_arm = 1'b0;
  logic [7:0] m_idx = '0, m_dat = '0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tx_srcaddr_inserter u_tx_srcaddr_inserter (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .out_valid(out_valid),
    .out_sof(out_sof), .out_eof(out_eof), .out_data(out_data)
  );

  function automatic void model_write(input logic [7:0] a, input logic [7:0] v);
    case (a)
      8'h07: m_en = v[0];
      8'h08: m_dat = v;
      8'h09: m_idx = v;
      8'h0A: begin
        if (!v[0] && m_arm && m_idx < 6) m_store[m_idx] = m_dat;
        m_arm = v[0];
      end
      default: ;
    endcase
  endfunction

  task automatic reg_write(input logic [7:0] a, input logic [7:0] v);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    model_write(a, v);
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic prog_slot(input logic [7:0] idx, input logic [7:0] v);
    reg_write(8'h09, idx);
    reg_write(8'h08, v);
    reg_write(8'h0A, 8'h01);
    reg_write(8'h0A, 8'h00);
  endtask

  // Driver: pushes the expected beat for every byte it sends.
  // toggle_at >= 0 writes the enable with toggle_val in that byte's cycle.
  task automatic send_frame(input int len, input int gap, input logic [7:0] seed,
                            input int toggle_at, input logic toggle_val,
                            input string tag);
    logic fe;
    fe = m_en;
    for (int i = 0; i < len; i++) begin
      exp_t x;
      logic [7:0] d;
      @(posedge clk); #1;
      d = seed + 8'(i * 7);
      in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == len - 1); in_data = d;
      if (i == toggle_at) begin
        reg_wr = 1'b1; reg_addr = 8'h07; reg_wdata = {7'b0, toggle_val};
        model_write(8'h07, {7'b0, toggle_val});
      end else begin
        reg_wr = 1'b0;
      end
      x.d = (fe && i >= 6 && i <= 11) ? m_store[i-6] : d;
      x.s = (i == 0); x.e = (i == len - 1); x.cyc = cyc; x.tag = tag;
      q.push_back(x);
      if (gap > 0) begin
        @(posedge clk); #1;
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; reg_wr = 1'b0;
        repeat (gap - 1) @(posedge clk);
      end
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; reg_wr = 1'b0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected output byte actual=%02h expected=none", out_data);
      end else begin
        exp_t x;
        x = q.pop_front();
        if (out_data !== x.d || out_sof !== x.s || out_eof !== x.e || cyc != x.cyc + 1) begin
          errors++;
          $display("FAIL %s actual=%02h sof=%0b eof=%0b cyc=%0d expected=%02h sof=%0b eof=%0b cyc=%0d",
                   x.tag, out_data, out_sof, out_eof, cyc, x.d, x.s, x.e, x.cyc + 1);
        end
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 6; k++) m_store[k] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== 8'h00 || out_sof !== 1'b0 || out_eof !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset outputs actual=%0b/%02h expected=0/00", out_valid, out_data);
    end

    send_frame(20, 0, 8'h10, -1, 1'b0, "R3 enable off");
    reg_write(8'h07, 8'h01);
    send_frame(20, 0, 8'h20, -1, 1'b0, "R1 reset store zeros");
    prog_slot(0, 8'h11); prog_slot(1, 8'h22); prog_slot(2, 8'h33);
    prog_slot(3, 8'h44); prog_slot(4, 8'h55); prog_slot(5, 8'h66);
    send_frame(60, 0, 8'h30, -1, 1'b0, "R4 slot order");
    reg_write(8'h07, 8'h00);
    send_frame(30, 0, 8'h40, -1, 1'b0, "R3 disabled again");
    reg_write(8'h07, 8'h01);
    reg_write(8'h09, 8'h02); reg_write(8'h08, 8'hAA); reg_write(8'h0A, 8'h00);
    send_frame(14, 0, 8'h50, -1, 1'b0, "R5 lone zero no commit");
    reg_write(8'h0A, 8'h01);
    send_frame(14, 0, 8'h58, -1, 1'b0, "R5 lone one no commit");
    reg_write(8'h08, 8'hC3); reg_write(8'h0A, 8'h00);
    send_frame(14, 0, 8'h5C, -1, 1'b0, "R5 commit uses latest data");
    prog_slot(7, 8'hEE);
    prog_slot(3, 8'h5A);
    send_frame(16, 0, 8'h60, -1, 1'b0, "R6 index select and out of range");
    send_frame(20, 0, 8'h70, 4, 1'b0, "R7 disable mid frame");
    send_frame(20, 0, 8'h80, -1, 1'b0, "R7 disable at next frame");
    send_frame(20, 0, 8'h90, 8, 1'b1, "R7 enable mid frame");
    send_frame(20, 0, 8'hA0, -1, 1'b0, "R7 enable at next frame");
    send_frame(15, 2, 8'hB0, -1, 1'b0, "R9 gapped frame");
    send_frame(9, 0, 8'hC0, -1, 1'b0, "R8 short frame");
    send_frame(5, 0, 8'hD0, -1, 1'b0, "R8 tiny frame");

    repeat (5) @(posedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R2 missing output actual=%0d pending expected=0", q.size());
    end
    finish_run();
  end
endmodule